// File: doc/BRIEF.md
# Data Memory Address Generation Unit

This block produces the effective data address for every load and store of a small 8-bit controller core. One request strobe carries an addressing mode, a pointer choice, a short displacement and a full 16-bit absolute address. The block picks the right source, applies the offset or the automatic step, and then sorts the result into one of three windows of a single linear data space. The three windows are the general-purpose register file, the I/O registers and the internal SRAM. Every region is reached through the same address arithmetic.

The block keeps its own copies of the three 16-bit pointer pairs. When a pre-decrement or post-increment request changes a pointer, the block sends the new value back to the register file through a write-back strobe. When the datapath writes a pointer register by some other route, the load port keeps the copy coherent. All results come out on registered outputs one cycle after the request. A request the block cannot serve produces an illegal flag in place of an address.

Top module: `dmem_agu`

## Requirements
- R1: After reset every output is zero and all three pointers hold 0x0000.
- R2: Mode code 0 (direct) gives an effective address equal to the 16-bit direct address input. It produces no write-back.
- R3: Mode code 1 (indirect) gives an effective address equal to the selected pointer and leaves the pointer unchanged. Pointer select 0 is X, 1 is Y and 2 is Z.
- R4: Mode code 2 (displacement) gives Y or Z plus the zero-extended 6-bit displacement (0 to 63), taken modulo 2^16, with no write-back.
- R5: Mode code 3 (pre-decrement) gives the pointer minus one, modulo 2^16, as the address. The same value is written back to that pointer.
- R6: Mode code 4 (post-increment) gives the current pointer as the address. The pointer plus one, modulo 2^16, is written back.
- R7: Addresses 0x000 to 0x01F assert region bit 0 (register file), and the offset equals the address.
- R8: Addresses 0x020 to 0x05F assert region bit 1 (I/O), and the offset is the address minus 0x20.
- R9: Addresses 0x060 to 0x45F assert region bit 2 (SRAM), and the offset is the address minus 0x60.
- R10: An address of 0x460 or above raises the out-of-range flag and drives region and offset to zero.
- R11: The following requests raise the illegal flag with no address valid and no write-back, and leave every pointer unchanged: displacement with X, pointer select 3 in any pointer mode, and mode codes 5 to 7.
- R12: When no request is present, a load writes the given value into the pointer it selects. A load that arrives in the same cycle as a request is ignored.
- R13: The outputs of a request appear exactly one clock after the strobe and last for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Address request strobe |
| mode_i | input | 3 | Addressing mode code |
| ptr_sel_i | input | 2 | Pointer choice: 0 X, 1 Y, 2 Z |
| disp_i | input | 6 | Displacement for mode 2 |
| dir_addr_i | input | 16 | Absolute address for mode 0 |
| ld_en_i | input | 1 | Pointer load strobe |
| ld_sel_i | input | 2 | Pointer that the load targets |
| ld_val_i | input | 16 | Value to load |
| addr_valid_o | output | 1 | Effective address is valid |
| eff_addr_o | output | 16 | Effective address |
| region_o | output | 3 | One-hot region: bit0 registers, bit1 I/O, bit2 SRAM |
| offset_o | output | 10 | Offset within the selected region |
| oor_o | output | 1 | Address lies outside the decoded space |
| illegal_o | output | 1 | Request could not be served |
| wb_valid_o | output | 1 | Pointer write-back strobe |
| wb_sel_o | output | 2 | Pointer being written back |
| wb_val_o | output | 16 | Updated pointer value |

## Verification
The bench sweeps every direct address from zero past the top of SRAM, so every region edge is tested on both sides. A decoder with an off-by-one boundary would send 0x1F, 0x5F or 0x45F to the wrong window, and a missing range check would let 0x460 through as SRAM. Displacement runs over all 64 offsets, from a base that crosses the out-of-range edge and from a base that wraps past 0xFFFF. Pre-decrement and post-increment are taken through the wrap points. A design that used the pre-step value, or stepped after the address in the wrong mode, would miss the expected address by one. Illegal requests and loads that collide with a request are each followed by an indirect read, which exposes any pointer they should not have touched.

// File: rtl/dmem_agu_pkg.sv
package dmem_agu_pkg;
  localparam int AW = 16;

  typedef enum logic [2:0] {
    AM_DIRECT  = 3'd0,
    AM_IND     = 3'd1,
    AM_DISP    = 3'd2,
    AM_PREDEC  = 3'd3,
    AM_POSTINC = 3'd4
  } am_e;

  localparam logic [1:0] PSEL_X = 2'd0;
  localparam logic [1:0] PSEL_Y = 2'd1;
  localparam logic [1:0] PSEL_Z = 2'd2;

  function automatic logic [AW-1:0] f_step(input logic [AW-1:0] p, input logic up);
    return up ? p + AW'(1) : p - AW'(1);
  endfunction

  function automatic logic [AW-1:0] f_disp(input logic [AW-1:0] base, input logic [5:0] d);
    return base + AW'(d);
  endfunction
endpackage

// File: rtl/dmem_agu_ptrfile.sv
module dmem_agu_ptrfile
  import dmem_agu_pkg::*;
#(
  parameter int NPTR = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd_en,
  input  logic [1:0]               upd_sel,
  input  logic [AW-1:0]            upd_val,
  input  logic                     ld_en,
  input  logic                     req_busy,
  input  logic [1:0]               ld_sel,
  input  logic [AW-1:0]            ld_val,
  output logic [NPTR-1:0][AW-1:0]  ptr
);
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    wire hit_upd = upd_en && (upd_sel == 2'(g));
    wire hit_ld  = ld_en && !req_busy && (ld_sel == 2'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)       ptr[g] <= '0;
      else if (hit_upd) ptr[g] <= upd_val;
      else if (hit_ld)  ptr[g] <= ld_val;
    end
  end
endmodule

// File: rtl/dmem_agu_calc.sv
module dmem_agu_calc
  import dmem_agu_pkg::*;
#(
  parameter int NPTR = 3
) (
  input  logic [2:0]              mode,
  input  logic [1:0]              sel,
  input  logic [5:0]              disp,
  input  logic [AW-1:0]           dir_addr,
  input  logic [NPTR-1:0][AW-1:0] ptr,
  output logic [AW-1:0]           ea,
  output logic                    illegal,
  output logic                    step_en,
  output logic [AW-1:0]           step_val
);
  logic          sel_ok;
  logic [AW-1:0] cur;

  assign sel_ok = (32'(sel) < NPTR);
  assign cur    = sel_ok ? ptr[sel] : '0;

  always_comb begin
    ea       = '0;
    illegal  = 1'b0;
    step_en  = 1'b0;
    step_val = cur;
    case (mode)
      AM_DIRECT: ea = dir_addr;
      AM_IND: begin
        illegal = !sel_ok;
        ea      = cur;
      end
      AM_DISP: begin
        illegal = !sel_ok || (sel == PSEL_X);
        ea      = f_disp(cur, disp);
      end
      AM_PREDEC: begin
        illegal  = !sel_ok;
        step_val = f_step(cur, 1'b0);
        ea       = step_val;
        step_en  = sel_ok;
      end
      AM_POSTINC: begin
        illegal  = !sel_ok;
        step_val = f_step(cur, 1'b1);
        ea       = cur;
        step_en  = sel_ok;
      end
      default: illegal = 1'b1;
    endcase
    if (illegal) ea = '0;
  end
endmodule

// File: rtl/dmem_agu_decode.sv
module dmem_agu_decode
  import dmem_agu_pkg::*;
#(
  parameter int RF_SIZE   = 32,
  parameter int IO_SIZE   = 64,
  parameter int SRAM_SIZE = 1024,
  parameter int OFS_W     = 10
) (
  input  logic [AW-1:0]    addr,
  output logic [2:0]       region,
  output logic [OFS_W-1:0] offset,
  output logic             oor
);
  localparam logic [AW-1:0] IO_BASE   = AW'(RF_SIZE);
  localparam logic [AW-1:0] SRAM_BASE = AW'(RF_SIZE + IO_SIZE);
  localparam logic [AW-1:0] TOP       = AW'(RF_SIZE + IO_SIZE + SRAM_SIZE);

  wire in_rf = addr < IO_BASE;
  wire in_io = !in_rf && (addr < SRAM_BASE);
  wire in_sr = (addr >= SRAM_BASE) && (addr < TOP);

  assign oor    = addr >= TOP;
  assign region = {in_sr, in_io, in_rf};

  always_comb begin
    offset = '0;
    if (in_rf)      offset = OFS_W'(addr);
    else if (in_io) offset = OFS_W'(addr - IO_BASE);
    else if (in_sr) offset = OFS_W'(addr - SRAM_BASE);
  end
endmodule

// File: rtl/dmem_agu.sv
module dmem_agu
  import dmem_agu_pkg::*;
#(
  parameter int NPTR      = 3,
  parameter int RF_SIZE   = 32,
  parameter int IO_SIZE   = 64,
  parameter int SRAM_SIZE = 1024,
  parameter int OFS_W     = $clog2(SRAM_SIZE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [2:0]       mode_i,
  input  logic [1:0]       ptr_sel_i,
  input  logic [5:0]       disp_i,
  input  logic [15:0]      dir_addr_i,
  input  logic             ld_en_i,
  input  logic [1:0]       ld_sel_i,
  input  logic [15:0]      ld_val_i,
  output logic             addr_valid_o,
  output logic [15:0]      eff_addr_o,
  output logic [2:0]       region_o,
  output logic [OFS_W-1:0] offset_o,
  output logic             oor_o,
  output logic             illegal_o,
  output logic             wb_valid_o,
  output logic [1:0]       wb_sel_o,
  output logic [15:0]      wb_val_o
);
  localparam logic [AW-1:0] SPACE_TOP = AW'(RF_SIZE + IO_SIZE + SRAM_SIZE);

  logic [NPTR-1:0][AW-1:0] ptr;
  logic [AW-1:0]           ea_c, step_val_c;
  logic                    illegal_c, step_en_c;
  logic [2:0]              region_c;
  logic [OFS_W-1:0]        offset_c;
  logic                    oor_c;
  logic                    upd_fire;
  logic [2:0]              mode_q;

  assign upd_fire = req_i && step_en_c && !illegal_c;

  dmem_agu_ptrfile #(.NPTR(NPTR)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .upd_en(upd_fire), .upd_sel(ptr_sel_i), .upd_val(step_val_c),
    .ld_en(ld_en_i), .req_busy(req_i), .ld_sel(ld_sel_i), .ld_val(ld_val_i),
    .ptr(ptr)
  );

  dmem_agu_calc #(.NPTR(NPTR)) u_calc (
    .mode(mode_i), .sel(ptr_sel_i), .disp(disp_i), .dir_addr(dir_addr_i),
    .ptr(ptr), .ea(ea_c), .illegal(illegal_c),
    .step_en(step_en_c), .step_val(step_val_c)
  );

  dmem_agu_decode #(
    .RF_SIZE(RF_SIZE), .IO_SIZE(IO_SIZE), .SRAM_SIZE(SRAM_SIZE), .OFS_W(OFS_W)
  ) u_dec (
    .addr(ea_c), .region(region_c), .offset(offset_c), .oor(oor_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_valid_o <= 1'b0;
      eff_addr_o   <= '0;
      region_o     <= '0;
      offset_o     <= '0;
      oor_o        <= 1'b0;
      illegal_o    <= 1'b0;
      wb_valid_o   <= 1'b0;
      wb_sel_o     <= '0;
      wb_val_o     <= '0;
      mode_q       <= '0;
    end else begin
      addr_valid_o <= req_i && !illegal_c;
      illegal_o    <= req_i && illegal_c;
      eff_addr_o   <= (req_i && !illegal_c) ? ea_c : '0;
      region_o     <= (req_i && !illegal_c) ? region_c : '0;
      offset_o     <= (req_i && !illegal_c) ? offset_c : '0;
      oor_o        <= req_i && !illegal_c && oor_c;
      wb_valid_o   <= upd_fire;
      wb_sel_o     <= upd_fire ? ptr_sel_i : '0;
      wb_val_o     <= upd_fire ? step_val_c : '0;
      mode_q       <= req_i ? mode_i : '0;
    end
  end

  AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(region_o)); // R7
  AST_OOR_NO_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    oor_o |-> (region_o == 3'b000 && eff_addr_o >= SPACE_TOP)); // R10
  AST_INRANGE_HAS_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && !oor_o) |-> $countones(region_o) == 1); // R9
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!addr_valid_o && !wb_valid_o)); // R11
  AST_WB_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> addr_valid_o); // R5
  AST_PREDEC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid_o && mode_q == AM_PREDEC) |-> wb_val_o == eff_addr_o); // R5
  AST_POSTINC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid_o && mode_q == AM_POSTINC) |-> wb_val_o == eff_addr_o + 16'd1); // R6
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_i) |-> (!addr_valid_o && !illegal_o)); // R13
endmodule

// File: tb/sim_dmem_agu.sv
module sim_dmem_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [1:0]  ptr_sel_i = '0;
  logic [5:0]  disp_i = '0;
  logic [15:0] dir_addr_i = '0;
  logic        ld_en_i = 1'b0;
  logic [1:0]  ld_sel_i = '0;
  logic [15:0] ld_val_i = '0;
  logic        addr_valid_o, oor_o, illegal_o, wb_valid_o;
  logic [15:0] eff_addr_o, wb_val_o;
  logic [2:0]  region_o;
  logic [9:0]  offset_o;
  logic [1:0]  wb_sel_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model_ptr [3];

  always #4 clk = ~clk;

  dmem_agu u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
    .ptr_sel_i(ptr_sel_i), .disp_i(disp_i), .dir_addr_i(dir_addr_i),
    .ld_en_i(ld_en_i), .ld_sel_i(ld_sel_i), .ld_val_i(ld_val_i),
    .addr_valid_o(addr_valid_o), .eff_addr_o(eff_addr_o), .region_o(region_o),
    .offset_o(offset_o), .oor_o(oor_o), .illegal_o(illegal_o),
    .wb_valid_o(wb_valid_o), .wb_sel_o(wb_sel_o), .wb_val_o(wb_val_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected region/offset/oor computed arithmetically
  task automatic check_decode(input string tag, input logic [15:0] a);
    int ai;
    ai = int'(a);
    if (ai < 32) begin
      check({tag, " R7 region"}, 32'(region_o), 32'd1);
      check({tag, " R7 offset"}, 32'(offset_o), 32'(ai));
      check({tag, " R7 oor"}, 32'(oor_o), 32'd0);
    end else if (ai < 96) begin
      check({tag, " R8 region"}, 32'(region_o), 32'd2);
      check({tag, " R8 offset"}, 32'(offset_o), 32'(ai - 32));
      check({tag, " R8 oor"}, 32'(oor_o), 32'd0);
    end else if (ai < 1120) begin
      check({tag, " R9 region"}, 32'(region_o), 32'd4);
      check({tag, " R9 offset"}, 32'(offset_o), 32'(ai - 96));
      check({tag, " R9 oor"}, 32'(oor_o), 32'd0);
    end else begin
      check({tag, " R10 region"}, 32'(region_o), 32'd0);
      check({tag, " R10 offset"}, 32'(offset_o), 32'd0);
      check({tag, " R10 oor"}, 32'(oor_o), 32'd1);
    end
  endtask

  // one request: drive at negedge, outputs visible at following negedge
  task automatic issue(input logic [2:0] m, input logic [1:0] s,
                       input logic [5:0] d, input logic [15:0] da);
    @(negedge clk);
    req_i = 1'b1; mode_i = m; ptr_sel_i = s; disp_i = d; dir_addr_i = da;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic load_ptr(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    ld_en_i = 1'b1; ld_sel_i = s; ld_val_i = v;
    @(negedge clk);
    ld_en_i = 1'b0;
    if (s < 2'd3) model_ptr[s] = v;
  endtask

  task automatic expect_addr(input string tag, input logic [15:0] a, input logic wb,
                             input logic [1:0] s, input logic [15:0] wv);
    check({tag, " valid"}, 32'(addr_valid_o), 32'd1);
    check({tag, " illegal"}, 32'(illegal_o), 32'd0);
    check({tag, " ea"}, 32'(eff_addr_o), 32'(a));
    check({tag, " wb"}, 32'(wb_valid_o), 32'(wb));
    if (wb) begin
      check({tag, " wbsel"}, 32'(wb_sel_o), 32'(s));
      check({tag, " wbval"}, 32'(wb_val_o), 32'(wv));
    end
    check_decode(tag, a);
  endtask

  task automatic expect_illegal(input string tag);
    check({tag, " illegal"}, 32'(illegal_o), 32'd1);
    check({tag, " valid"}, 32'(addr_valid_o), 32'd0);
    check({tag, " wb"}, 32'(wb_valid_o), 32'd0);
  endtask

  task automatic read_ptr(input string tag, input logic [1:0] s);
    issue(3'd1, s, 6'd0, 16'h0);
    expect_addr(tag, model_ptr[s], 1'b0, s, 16'h0);
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] p;
    for (int i = 0; i < 3; i++) model_ptr[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 valid", 32'(addr_valid_o), 0);
    check("R1 ea", 32'(eff_addr_o), 0);
    check("R1 region", 32'(region_o), 0);
    check("R1 flags", {oor_o, illegal_o, wb_valid_o}, 0);
    for (int s = 0; s < 3; s++) read_ptr("R1 ptr", 2'(s));

    // R2 direct sweep covers R7..R10 boundaries exhaustively
    for (int a = 0; a < 1200; a++) begin
      issue(3'd0, 2'd0, 6'd0, 16'(a));
      expect_addr("R2 direct", 16'(a), 1'b0, 2'd0, 16'h0);
    end
    issue(3'd0, 2'd1, 6'd0, 16'hFFFF);
    expect_addr("R2 R10 top", 16'hFFFF, 1'b0, 2'd0, 16'h0);

    // R13 single-cycle pulse
    @(negedge clk);
    check("R13 pulse", 32'(addr_valid_o), 0);

    // R12 loads and R3 indirect
    load_ptr(2'd0, 16'h0123);
    load_ptr(2'd1, 16'h0440);
    load_ptr(2'd2, 16'hFFF0);
    for (int s = 0; s < 3; s++) read_ptr("R3 R12 ind", 2'(s));

    // R4 displacement over all offsets, Y crosses 0x460, Z wraps
    for (int s = 1; s < 3; s++)
      for (int d = 0; d < 64; d++) begin
        issue(3'd2, 2'(s), 6'(d), 16'h0);
        expect_addr("R4 disp", model_ptr[s] + 16'(d), 1'b0, 2'(s), 16'h0);
      end

    // R5 pre-decrement with wrap at zero
    load_ptr(2'd0, 16'h0002);
    for (int k = 0; k < 4; k++) begin
      p = model_ptr[0] - 16'd1;
      issue(3'd3, 2'd0, 6'd0, 16'h0);
      expect_addr("R5 predec", p, 1'b1, 2'd0, p);
      model_ptr[0] = p;
    end
    read_ptr("R5 after", 2'd0);

    // R6 post-increment with wrap at 0xFFFF
    load_ptr(2'd2, 16'hFFFE);
    for (int k = 0; k < 4; k++) begin
      p = model_ptr[2];
      issue(3'd4, 2'd2, 6'd0, 16'h0);
      expect_addr("R6 postinc", p, 1'b1, 2'd2, p + 16'd1);
      model_ptr[2] = p + 16'd1;
    end
    read_ptr("R6 after", 2'd2);
    load_ptr(2'd1, 16'h005F);
    issue(3'd4, 2'd1, 6'd0, 16'h0);
    expect_addr("R6 R8 edge", 16'h005F, 1'b1, 2'd1, 16'h0060);
    model_ptr[1] = 16'h0060;

    // R11 illegal requests leave pointers untouched
    issue(3'd2, 2'd0, 6'd5, 16'h0);
    expect_illegal("R11 dispX");
    issue(3'd3, 2'd3, 6'd0, 16'h0);
    expect_illegal("R11 sel3 predec");
    issue(3'd4, 2'd3, 6'd0, 16'h0);
    expect_illegal("R11 sel3 postinc");
    for (int m = 5; m < 8; m++) begin
      issue(3'(m), 2'd1, 6'd0, 16'h0);
      expect_illegal("R11 badmode");
    end
    for (int s = 0; s < 3; s++) read_ptr("R11 ptr kept", 2'(s));

    // R12 load coinciding with a request is ignored
    @(negedge clk);
    req_i = 1'b1; mode_i = 3'd1; ptr_sel_i = 2'd2;
    ld_en_i = 1'b1; ld_sel_i = 2'd0; ld_val_i = 16'hBEEF;
    @(negedge clk);
    req_i = 1'b0; ld_en_i = 1'b0;
    expect_addr("R12 req ind", model_ptr[2], 1'b0, 2'd2, 16'h0);
    read_ptr("R12 ld ignored", 2'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule